// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits behind the serial front end of an EEPROM. It gathers the data bytes of a memory write command into a page latch of `PAGE_BYTES` entries and then hands them to the array. A command begins with a start pulse that carries the target address. Its upper bits choose the page, and its low `IDX_W` bits choose the first latch entry. Each received byte goes into the current entry and advances the index, which wraps inside the page. Sending more bytes than a page holds therefore replaces bytes that were stored earlier.

When chip select rises, the front end reports how many serial clocks the frame held. The block starts programming only if that count is the 24 header clocks plus a whole number (at least one) of data bytes. Any other count cancels the command. Programming is a busy period of exactly `WRITE_CYCLES` clocks. During its first `PAGE_BYTES` cycles, the entries are scanned in ascending index order, and an array write strobe is issued for each entry that was loaded. Entries that were not loaded produce no strobe, so those locations keep their old contents. A one-cycle completion pulse in the last busy cycle tells the surrounding logic to clear its write-enable latch.

The controller has three states: `ST_IDLE`, `ST_COLLECT` and `ST_PROGRAM`. The transitions are:
- `ST_IDLE` to `ST_COLLECT` on a start pulse (the latch valid mask is cleared).
- `ST_COLLECT` to `ST_PROGRAM` on a chip-select rise with a legal count.
- `ST_COLLECT` to `ST_IDLE` on a chip-select rise with any other count (cancel).
- `ST_PROGRAM` to `ST_IDLE` in the last busy cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `arr_we` and `done` are 0.
- R2: The byte latched at load k of a command (k counted from 0) is written to the array address whose upper bits (above bit 4) equal those of the start address and whose low 5 bits equal (start low bits + k) mod 32. The upper bits never change.
- R3: When more than 32 bytes are loaded, the index wraps, and the later byte replaces the earlier one in the same entry. Only the latest value is written.
- R4: A chip-select rise in `ST_COLLECT` starts programming only when `bit_count` is at least 32 and `bit_count` minus 24 is a multiple of 8. `busy` rises in the cycle after that rise.
- R5: A chip-select rise with any other count, including 24, returns the block to idle. It produces no array write and no busy period.
- R6: `busy` stays 1 for exactly `WRITE_CYCLES` consecutive cycles per commit and is 0 at all other times.
- R7: During a commit, `arr_we` pulses once for each loaded entry and never for an unloaded one. The pulses come in ascending index order within the first 32 busy cycles. Unloaded locations keep their previous contents.
- R8: `done` is 1 for exactly one cycle, the last busy cycle, and `busy` is 0 in the following cycle.
- R9: Start pulses, byte strobes and chip-select rises that arrive while `busy` is 1 are ignored. They cause neither a later write nor a second busy period.
- R10: Byte strobes outside a command are ignored. A new start pulse discards the loaded marks of the previous command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse marking a decoded memory write command |
| cmd_addr | input | ADDR_W | Start address, sampled with `cmd_start` |
| byte_stb | input | 1 | One-cycle pulse: a complete data byte has been received |
| byte_data | input | DATA_W | Data byte, valid with `byte_stb` |
| cs_rise | input | 1 | One-cycle pulse: chip select went inactive |
| bit_count | input | CNT_W | Serial clocks counted in the frame, valid with `cs_rise` |
| busy | output | 1 | Internal programming in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array byte data |
| done | output | 1 | One-cycle completion pulse (clears the write-enable latch) |

## Verification
The assertions assume the following about the inputs:
- Every input is a one-cycle pulse from a front end that has already checked the write-enable latch and the protection.
- `bit_count` is meaningful only together with `cs_rise`.
- `cs_rise` and `byte_stb` never arrive in the same cycle.

The stimulus drives each pulse for exactly one clock, on the falling edge. It always separates the last byte strobe from the chip-select rise by at least one cycle. It presents counts both on and off the byte boundary, and it deliberately injects traffic during a busy period and outside a command to cover the ignored cases.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2
    } pwb_state_e;

    localparam int unsigned HEADER_CLOCKS = 24;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0]     entry_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g]  <= '0;
                loaded_q[g] <= 1'b0;
            end else if (clear) begin
                loaded_q[g] <= 1'b0;
            end else if (hit) begin
                entry_q[g]  <= wr_data;
                loaded_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data  = entry_q[rd_idx];
    assign rd_valid = loaded_q[rd_idx];
endmodule

// File: rtl/pwb_frame_check.sv
module pwb_frame_check #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HDR_BITS = 24
) (
    input  logic [CNT_W-1:0] bit_count,
    output logic             commit_ok
);
    localparam logic [CNT_W-1:0] MIN_CLOCKS = CNT_W'(HDR_BITS + DATA_W);
    localparam logic [CNT_W-1:0] HDR_C      = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] BYTE_C     = CNT_W'(DATA_W);

    logic [CNT_W-1:0] payload;

    always_comb begin
        payload   = bit_count - HDR_C;
        commit_ok = (bit_count >= MIN_CLOCKS) && ((payload % BYTE_C) == '0);
    end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int unsigned WRITE_CYCLES = 625000,
    localparam int unsigned TW          = $clog2(WRITE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    output logic [TW-1:0] count,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= '0;
        else if (run)    count <= count + 1'b1;
    end

    assign last = (count == TW'(WRITE_CYCLES - 1));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PAGE_BYTES   = 32,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned WRITE_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic [CNT_W-1:0]  bit_count,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              done
);
    import pwb_pkg::*;

    localparam int unsigned IDX_W = $clog2(PAGE_BYTES);
    localparam int unsigned TW    = $clog2(WRITE_CYCLES + 1);
    localparam int unsigned UP_W  = ADDR_W - IDX_W;

    pwb_state_e state_q, state_d;

    logic [UP_W-1:0]   page_q;
    logic [IDX_W-1:0]  idx_q;
    logic              commit_ok;
    logic [TW-1:0]     tcount;
    logic              tlast;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              start_take;
    logic              byte_take;
    logic              commit_go;
    logic              scan_on;

    assign start_take = (state_q == ST_IDLE) && cmd_start;
    assign byte_take  = (state_q == ST_COLLECT) && byte_stb && !cs_rise;
    assign commit_go  = (state_q == ST_COLLECT) && cs_rise && commit_ok;
    assign scan_on    = (tcount < TW'(PAGE_BYTES));

    pwb_frame_check #(
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .HDR_BITS(HEADER_CLOCKS)
    ) u_frame (
        .bit_count(bit_count),
        .commit_ok(commit_ok)
    );

    pwb_page_latch #(
        .PAGE_BYTES(PAGE_BYTES),
        .DATA_W    (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_take),
        .wr_en   (byte_take),
        .wr_idx  (idx_q),
        .wr_data (byte_data),
        .rd_idx  (tcount[IDX_W-1:0]),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    pwb_timer #(
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (commit_go),
        .run  (state_q == ST_PROGRAM),
        .count(tcount),
        .last (tlast)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_start) state_d = ST_COLLECT;
            ST_COLLECT: if (cs_rise)   state_d = commit_ok ? ST_PROGRAM : ST_IDLE;
            ST_PROGRAM: if (tlast)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // page and index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            idx_q  <= '0;
        end else if (start_take) begin
            page_q <= cmd_addr[ADDR_W-1:IDX_W];
            idx_q  <= cmd_addr[IDX_W-1:0];
        end else if (byte_take) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_PROGRAM);
        arr_we    = (state_q == ST_PROGRAM) && scan_on && rd_valid;
        arr_addr  = {page_q, tcount[IDX_W-1:0]};
        arr_wdata = rd_data;
        done      = (state_q == ST_PROGRAM) && tlast;
    end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned IDX_W        = 5,
    parameter int unsigned WRITE_CYCLES = 625000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic [CNT_W-1:0]  bit_count,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              done
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_fall_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_start_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_rise) && ($past(bit_count) >= CNT_W'(32))
                         && ($past(bit_count[2:0]) == 3'd0)));

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WRITE_CYCLES));

    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && busy && $past(busy)) |->
            (arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W])));
endmodule

bind eeprom_page_writer pwb_checker #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .IDX_W       (IDX_W),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_pwb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_rise  (cs_rise),
    .bit_count(bit_count),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .done     (done)
);

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
    localparam int WC = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [10:0] cmd_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cs_rise = 1'b0;
    logic [15:0] bit_count = '0;
    logic        busy, arr_we, done;
    logic [10:0] arr_addr;
    logic [7:0]  arr_wdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;
    bit cmp_en = 0;

    always #4 clk = ~clk;

    eeprom_page_writer #(.WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_count(bit_count), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .done(done)
    );

    // behavioural reference: 0 idle, 1 collecting, 2 programming
    int   m_st = 0, m_t = 0, m_idx = 0, m_base = 0;
    logic [7:0] m_byte [32];
    bit   m_ld [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_t <= 0;
            for (int i = 0; i < 32; i++) m_ld[i] <= 0;
        end else begin
            case (m_st)
                0: if (cmd_start) begin
                    m_st <= 1; m_base <= int'(cmd_addr) / 32 * 32;
                    m_idx <= int'(cmd_addr) % 32;
                    for (int i = 0; i < 32; i++) m_ld[i] <= 0;
                end
                1: if (cs_rise) begin
                    if (bit_count >= 32 && (bit_count - 24) % 8 == 0) begin
                        m_st <= 2; m_t <= 0;
                    end else m_st <= 0;
                end else if (byte_stb) begin
                    m_byte[m_idx] <= byte_data; m_ld[m_idx] <= 1;
                    m_idx <= (m_idx + 1) % 32;
                end
                default: if (m_t == WC - 1) m_st <= 0; else m_t <= m_t + 1;
            endcase
        end
    end

    // shadow of the array
    logic [7:0] shadow [2048];
    initial for (int i = 0; i < 2048; i++) shadow[i] = 8'hFF;
    always @(posedge clk) if (rst_n && arr_we) shadow[arr_addr] <= arr_wdata;

    int busy_rises = 0;
    int done_count = 0;
    int we_count = 0;
    logic prev_busy = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            automatic bit e_busy = (m_st == 2);
            automatic bit e_we   = e_busy && m_t < 32 && m_ld[m_t % 32];
            automatic bit e_done = e_busy && m_t == WC - 1;
            chk("R6 busy", int'(busy), int'(e_busy));
            chk("R7 arr_we", int'(arr_we), int'(e_we));
            chk("R8 done", int'(done), int'(e_done));
            if (e_we) begin
                chk("R2 arr_addr", int'(arr_addr), m_base + m_t);
                chk("R3 arr_wdata", int'(arr_wdata), int'(m_byte[m_t]));
            end
            if (busy && !prev_busy) busy_rises++;
            if (done) done_count++;
            if (arr_we) we_count++;
            prev_busy = busy;
        end
    end

    task automatic start_cmd(input logic [10:0] a);
        cmd_start = 1; cmd_addr = a; @(negedge clk); cmd_start = 0;
    endtask
    task automatic push(input logic [7:0] d);
        byte_stb = 1; byte_data = d; @(negedge clk); byte_stb = 0;
    endtask
    task automatic cs_up(input int n);
        cs_rise = 1; bit_count = 16'(n); @(negedge clk); cs_rise = 0;
    endtask
    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        int n, r0, d0, w0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 arr_we in reset", int'(arr_we), 0);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        chk("R1 busy after reset", int'(busy), 0);

        // single byte commit
        start_cmd(11'h123); push(8'hA5); @(negedge clk);
        d0 = done_count; w0 = we_count;
        cs_up(32);
        chk("R4 busy after legal count", int'(busy), 1);
        wait_idle(n);
        chk("R6 busy length", n, WC);
        chk("R8 one done pulse", done_count - d0, 1);
        chk("R7 one write strobe", we_count - w0, 1);
        chk("R2 byte at start", int'(shadow[11'h123]), 8'hA5);
        chk("R7 neighbour below kept", int'(shadow[11'h122]), 8'hFF);
        chk("R7 neighbour above kept", int'(shadow[11'h124]), 8'hFF);

        // wrap inside page, upper bits fixed
        start_cmd(11'h3FC);
        for (int k = 0; k < 6; k++) push(8'(8'h10 + k));
        cs_up(24 + 6 * 8);
        wait_idle(n);
        chk("R2 idx 28", int'(shadow[11'h3FC]), 8'h10);
        chk("R2 idx 31", int'(shadow[11'h3FF]), 8'h13);
        chk("R2 wrapped idx 0", int'(shadow[11'h3E0]), 8'h14);
        chk("R2 wrapped idx 1", int'(shadow[11'h3E1]), 8'h15);
        chk("R2 next page untouched", int'(shadow[11'h400]), 8'hFF);

        // more than a page: overwrite
        start_cmd(11'h040);
        for (int k = 0; k < 34; k++) push(8'(8'h40 + k));
        w0 = we_count;
        cs_up(24 + 34 * 8);
        wait_idle(n);
        chk("R3 idx 0 overwritten", int'(shadow[11'h040]), 8'h60);
        chk("R3 idx 1 overwritten", int'(shadow[11'h041]), 8'h61);
        chk("R3 idx 2 original", int'(shadow[11'h042]), 8'h42);
        chk("R3 idx 31 original", int'(shadow[11'h05F]), 8'h5F);
        chk("R7 strobes for full page", we_count - w0, 32);

        // cancelled frames
        r0 = busy_rises; w0 = we_count;
        start_cmd(11'h100); push(8'h01); push(8'h02); @(negedge clk);
        cs_up(36);
        repeat (WC + 4) @(negedge clk);
        start_cmd(11'h100); @(negedge clk);
        cs_up(24);
        repeat (4) @(negedge clk);
        chk("R5 no busy on bad count", busy_rises - r0, 0);
        chk("R5 no strobe on bad count", we_count - w0, 0);
        chk("R5 location kept", int'(shadow[11'h100]), 8'hFF);

        // traffic while busy
        r0 = busy_rises;
        start_cmd(11'h200); push(8'h11); @(negedge clk);
        cs_up(32);
        start_cmd(11'h300); push(8'h77); @(negedge clk);
        cs_up(32);
        wait_idle(n);
        repeat (WC + 4) @(negedge clk);
        chk("R9 single busy period", busy_rises - r0, 1);
        chk("R9 busy-time command dropped", int'(shadow[11'h300]), 8'hFF);
        chk("R9 real byte written", int'(shadow[11'h200]), 8'h11);

        // stray bytes and stale loaded marks
        push(8'h99); @(negedge clk);
        start_cmd(11'h520); push(8'h22); push(8'h23); push(8'h24); @(negedge clk);
        cs_up(24 + 24);
        wait_idle(n);
        chk("R10 stray byte did not shift", int'(shadow[11'h520]), 8'h22);
        chk("R10 entry 2", int'(shadow[11'h522]), 8'h24);
        start_cmd(11'h545); push(8'h55); @(negedge clk);
        cs_up(32);
        wait_idle(n);
        chk("R10 target byte", int'(shadow[11'h545]), 8'h55);
        chk("R10 stale entry 0 not written", int'(shadow[11'h540]), 8'hFF);
        chk("R10 stale entry 1 not written", int'(shadow[11'h541]), 8'hFF);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule